// File: doc/BRIEF.md
# Serial Audio Transmit Path

This block is the transmit half of a synchronous serial audio port running one word per frame. The host pushes data words into a one-word holding register or, when the queue is switched on, into an eight-entry first-in first-out queue. On each frame sync the oldest stored word moves into a shift register and leaves on the serial data pin, most significant bit first, one bit per bit-clock edge. The data output is enabled only while that word is on the pin.

Two status flags tell the host when to refill. The first is a holding-empty flag, used when the queue is off. The second is a low-water flag, used when the queue is on; it compares the fill level with a programmable threshold. A single transmit interrupt is formed from whichever flag belongs to the current mode, gated by a global enable and by that flag's own enable. If a frame starts while nothing is stored, the previous word goes out again and a sticky underrun flag is raised.

The bit clock arrives as `bit_tick`, a one-cycle strobe in the system clock domain that marks each rising bit-clock edge. Frame sync is one bit long and arrives together with the first data bit of the slot.

Top module: `sai_tx_path`

## Requirements
- R1: After reset, `sdata_oe` is 0, `sdata_o` is 0, `fifo_level` is 0, `hold_empty` is 1 and `underrun` is 0. With all interrupt enables clear, `irq` is 0.
- R2: A `bit_tick` with `fsync` high while `en` and `tx_en` are both 1 starts a slot. In the cycle after that tick, `sdata_oe` is 1 and `sdata_o` carries bit W-1 of the loaded word. Each later `bit_tick` presents the next lower bit, so the word goes out MSB first.
- R3: `sdata_oe` stays high for exactly W bit ticks and drops on the next tick. Whenever `sdata_oe` is 0, `sdata_o` is 0.
- R4: With `fifo_en`=0, storage holds one word. A write made while that word is held is ignored: the level stays 1 and the held word is the one sent.
- R5: With `fifo_en`=0, `hold_empty` equals (`fifo_level`==0), and `irq` = `tx_ie` & `hold_ie` & `hold_empty`. `fifo_ie` has no effect in this mode.
- R6: With `fifo_en`=1, up to 8 words are stored, a write made while 8 are stored is ignored, and words leave in the order they were written.
- R7: `fifo_low` is 1 exactly when `fifo_level` <= `thresh`, for thresholds 0 to 8. With `fifo_en`=1, `irq` = `tx_ie` & `fifo_ie` & `fifo_low`, and `hold_ie` has no effect.
- R8: A slot that starts while no word is stored sends the previously sent word again and sets `underrun` (reset value of that word is 0). `underrun` stays set until the next `wr_valid` cycle clears it.
- R9: While `en` or `tx_en` is 0, frame syncs start no slot, `sdata_oe` stays 0 and the stored words are not consumed.
- R10: `fifo_level` equals the number of words currently stored. It rises by one on each accepted write and falls by one at each slot start that takes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| tx_en | input | 1 | Transmitter enable |
| fifo_en | input | 1 | 1 selects the 8-word queue, 0 the single holding register |
| tx_ie | input | 1 | Global transmit interrupt enable |
| hold_ie | input | 1 | Enable for the holding-empty interrupt source |
| fifo_ie | input | 1 | Enable for the low-water interrupt source |
| thresh | input | 4 | Low-water threshold, 0 to 8 |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | W | Host write word |
| bit_tick | input | 1 | One-cycle strobe marking a rising bit-clock edge |
| fsync | input | 1 | Frame sync, sampled on `bit_tick` |
| sdata_o | output | 1 | Serial data |
| sdata_oe | output | 1 | Serial data output enable (pin is high-impedance when 0) |
| fifo_level | output | 4 | Number of stored words |
| hold_empty | output | 1 | No word stored |
| fifo_low | output | 1 | Fill level at or below threshold |
| underrun | output | 1 | A slot started with no stored word |
| irq | output | 1 | Transmit interrupt |

## Verification
The hardest states to reach from the ports are the queue edges. One is a full queue that refuses a ninth write. The other is a queue drained to empty, where the next frame replays the previous word. The stimulus fills the queue with nine distinct words and then runs eight complete frames, checking the level and the low-water flag after each one. A further frame then starts with nothing stored. Threshold values 0 and 8 are applied at an empty and a full queue to check both ends of the comparison.

// File: rtl/sai_tx_pkg.sv
package sai_tx_pkg;
  localparam int unsigned SAI_WORD_W = 8;
  localparam int unsigned SAI_DEPTH  = 8;

  typedef enum logic {
    SRC_HOLD = 1'b0,
    SRC_FIFO = 1'b1
  } irq_src_e;
endpackage

// File: rtl/sai_tx_fifo.sv
module sai_tx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] lvl_q, lvl_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (push) wp_d = bump(wp_q);
    if (pop)  rp_d = bump(rp_q);
    case ({push, pop})
      2'b10:   lvl_d = lvl_q + CW'(1);
      2'b01:   lvl_d = lvl_q - CW'(1);
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign level = lvl_q;
endmodule

// File: rtl/sai_tx_shifter.sv
module sai_tx_shifter #(
  parameter int unsigned W = 8,
  localparam int unsigned NW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         start,
  input  logic         bit_tick,
  input  logic [W-1:0] word,
  output logic         sdata,
  output logic         oe
);
  logic [W-1:0]  sh_q, sh_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          oe_q, oe_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    oe_d  = oe_q;
    if (!active) begin
      oe_d = 1'b0;
    end else if (start) begin
      sh_d  = word;
      cnt_d = NW'(W - 1);
      oe_d  = 1'b1;
    end else if (bit_tick && oe_q) begin
      if (cnt_q == '0) begin
        oe_d = 1'b0;
      end else begin
        sh_d  = sh_q << 1;
        cnt_d = cnt_q - NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      oe_q  <= oe_d;
    end
  end

  assign oe    = oe_q;
  assign sdata = oe_q & sh_q[W-1];
endmodule

// File: rtl/sai_tx_flags.sv
module sai_tx_flags #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] thresh,
  input  logic          fifo_en,
  input  logic          tx_ie,
  input  logic          hold_ie,
  input  logic          fifo_ie,
  input  logic          starve,
  input  logic          host_wr,
  output logic          hold_empty,
  output logic          fifo_low,
  output logic          underrun,
  output logic          irq
);
  import sai_tx_pkg::*;

  logic     ur_q, ur_d;
  irq_src_e src;

  always_comb begin
    ur_d = ur_q;
    if (host_wr) ur_d = 1'b0;
    if (starve)  ur_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ur_q <= 1'b0;
    else        ur_q <= ur_d;
  end

  assign hold_empty = (level == '0);
  assign fifo_low   = (level <= thresh);
  assign src        = fifo_en ? SRC_FIFO : SRC_HOLD;

  always_comb begin
    case (src)
      SRC_FIFO: irq = tx_ie & fifo_ie & fifo_low;
      default:  irq = tx_ie & hold_ie & hold_empty;
    endcase
  end

  assign underrun = ur_q;
endmodule

// File: rtl/sai_tx_path.sv
module sai_tx_path #(
  parameter int unsigned W     = sai_tx_pkg::SAI_WORD_W,
  parameter int unsigned DEPTH = sai_tx_pkg::SAI_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tx_en,
  input  logic          fifo_en,
  input  logic          tx_ie,
  input  logic          hold_ie,
  input  logic          fifo_ie,
  input  logic [CW-1:0] thresh,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_tick,
  input  logic          fsync,
  output logic          sdata_o,
  output logic          sdata_oe,
  output logic [CW-1:0] fifo_level,
  output logic          hold_empty,
  output logic          fifo_low,
  output logic          underrun,
  output logic          irq
);
  logic          active, start, have, accept, pop;
  logic [CW-1:0] cap, level;
  logic [W-1:0]  head, word, last_q, last_d;

  assign active = en & tx_en;
  assign start  = active & bit_tick & fsync;
  assign have   = (level != '0);
  assign pop    = start & have;
  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  assign accept = wr_valid & (level < cap);
  assign word   = have ? head : last_q;

  always_comb begin
    last_d = last_q;
    if (start) last_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  sai_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (wr_data),
    .pop       (pop),
    .head      (head),
    .level     (level)
  );

  sai_tx_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .start    (start),
    .bit_tick (bit_tick),
    .word     (word),
    .sdata    (sdata_o),
    .oe       (sdata_oe)
  );

  sai_tx_flags #(.CW(CW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (level),
    .thresh     (thresh),
    .fifo_en    (fifo_en),
    .tx_ie      (tx_ie),
    .hold_ie    (hold_ie),
    .fifo_ie    (fifo_ie),
    .starve     (start & ~have),
    .host_wr    (wr_valid),
    .hold_empty (hold_empty),
    .fifo_low   (fifo_low),
    .underrun   (underrun),
    .irq        (irq)
  );

  assign fifo_level = level;
endmodule

// File: rtl/sai_tx_path_chk.sv
module sai_tx_path_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tx_en,
  input logic          fifo_en,
  input logic          tx_ie,
  input logic          hold_ie,
  input logic          fifo_ie,
  input logic          bit_tick,
  input logic          fsync,
  input logic          sdata_o,
  input logic          sdata_oe,
  input logic [CW-1:0] fifo_level,
  input logic          underrun,
  input logic          irq
);
  logic slot_go;
  assign slot_go = en & tx_en & bit_tick & fsync;

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata_o);

  a_r2_slot_opens: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go |=> sdata_oe);

  a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && tx_en) |=> !sdata_oe);

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));

  a_r4_no_growth_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && fifo_level != '0) |=> fifo_level <= $past(fifo_level));

  a_r8_starve_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && fifo_level == '0) |=> underrun);

  a_r5_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tx_ie);

  a_r7_irq_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && fifo_en) |-> fifo_ie);
endmodule

bind sai_tx_path sai_tx_path_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .tx_en      (tx_en),
  .fifo_en    (fifo_en),
  .tx_ie      (tx_ie),
  .hold_ie    (hold_ie),
  .fifo_ie    (fifo_ie),
  .bit_tick   (bit_tick),
  .fsync      (fsync),
  .sdata_o    (sdata_o),
  .sdata_oe   (sdata_oe),
  .fifo_level (fifo_level),
  .underrun   (underrun),
  .irq        (irq)
);

// File: tb/tb_sai_tx_path.sv
module tb_sai_tx_path;
  localparam int W = 8;

  logic clk, rst_n;
  logic en, tx_en, fifo_en, tx_ie, hold_ie, fifo_ie;
  logic [3:0] thresh;
  logic wr_valid;
  logic [W-1:0] wr_data;
  logic bit_tick, fsync;
  logic sdata_o, sdata_oe, hold_empty, fifo_low, underrun, irq;
  logic [3:0] fifo_level;

  int n_chk = 0;
  int n_err = 0;

  sai_tx_path dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_en(tx_en), .fifo_en(fifo_en),
    .tx_ie(tx_ie), .hold_ie(hold_ie), .fifo_ie(fifo_ie), .thresh(thresh),
    .wr_valid(wr_valid), .wr_data(wr_data), .bit_tick(bit_tick), .fsync(fsync),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .fifo_level(fifo_level),
    .hold_empty(hold_empty), .fifo_low(fifo_low), .underrun(underrun), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [W-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic one_tick(input logic fs, output logic d, output logic oe);
    @(negedge clk);
    bit_tick = 1'b1;
    fsync    = fs;
    @(negedge clk);
    bit_tick = 1'b0;
    fsync    = 1'b0;
    d  = sdata_o;
    oe = sdata_oe;
    @(negedge clk);
  endtask

  // Runs one full slot and checks enable timing (R2, R3); returns the received word.
  task automatic run_frame(input string req, output logic [W-1:0] got);
    logic d, oe;
    int oe_bad;
    oe_bad = 0;
    got = '0;
    for (int i = 0; i < W; i++) begin
      one_tick(i == 0, d, oe);
      if (!oe) oe_bad++;
      got = {got[W-2:0], d};
    end
    check(req, "oe high for the whole slot (R3)", oe_bad, 0);
    one_tick(1'b0, d, oe);
    check(req, "oe low after slot (R3)", int'(oe), 0);
    check(req, "data low outside slot (R3)", int'(d), 0);
  endtask

  task automatic t_reset;
    check("R1", "oe", int'(sdata_oe), 0);
    check("R1", "data", int'(sdata_o), 0);
    check("R1", "level", int'(fifo_level), 0);
    check("R1", "hold_empty", int'(hold_empty), 1);
    check("R1", "underrun", int'(underrun), 0);
    check("R1", "irq", int'(irq), 0);
  endtask

  task automatic t_hold_mode;
    logic [W-1:0] got;
    fifo_en = 1'b0; tx_ie = 1'b1; hold_ie = 1'b0; fifo_ie = 1'b1;
    @(negedge clk);
    check("R5", "fifo_ie ignored in hold mode", int'(irq), 0);
    hold_ie = 1'b1;
    @(negedge clk);
    check("R5", "irq when empty", int'(irq), 1);
    host_write(8'hA5);
    check("R5", "hold_empty after write", int'(hold_empty), 0);
    check("R5", "irq cleared", int'(irq), 0);
    host_write(8'h3C);
    check("R4", "level after write into held register", int'(fifo_level), 1);
    run_frame("R2", got);
    check("R2", "word MSB first", int'(got), 'hA5);
    check("R4", "held word kept", int'(got), 'hA5);
    check("R5", "hold_empty after load", int'(hold_empty), 1);
    check("R5", "irq after load", int'(irq), 1);
    tx_ie = 1'b0;
    @(negedge clk);
    check("R5", "global enable gates irq", int'(irq), 0);
  endtask

  task automatic t_fifo_mode;
    logic [W-1:0] got;
    fifo_en = 1'b1; tx_ie = 1'b1; hold_ie = 1'b1; fifo_ie = 1'b0; thresh = 4'd2;
    @(negedge clk);
    check("R7", "hold_ie ignored in fifo mode", int'(irq), 0);
    fifo_ie = 1'b1;
    for (int i = 0; i < 9; i++) begin
      host_write(8'h10 + 8'(i));
      check("R10", "level after write", int'(fifo_level), (i < 8) ? i + 1 : 8);
    end
    check("R6", "ninth write ignored", int'(fifo_level), 8);
    check("R7", "low flag off at 8", int'(fifo_low), 0);
    check("R7", "irq off at 8", int'(irq), 0);
    thresh = 4'd8;
    @(negedge clk);
    check("R7", "threshold 8 at full", int'(fifo_low), 1);
    thresh = 4'd2;
    for (int i = 0; i < 8; i++) begin
      run_frame("R6", got);
      check("R6", "order", int'(got), 'h10 + i);
      check("R10", "level after slot", int'(fifo_level), 7 - i);
      check("R7", "low flag", int'(fifo_low), ((7 - i) <= 2) ? 1 : 0);
      check("R7", "irq", int'(irq), ((7 - i) <= 2) ? 1 : 0);
    end
    thresh = 4'd0;
    @(negedge clk);
    check("R7", "threshold 0 at empty", int'(fifo_low), 1);
  endtask

  task automatic t_underrun;
    logic [W-1:0] got;
    check("R8", "underrun clear before", int'(underrun), 0);
    run_frame("R8", got);
    check("R8", "last word replayed", int'(got), 'h17);
    check("R8", "underrun set", int'(underrun), 1);
    check("R8", "level stays 0", int'(fifo_level), 0);
    host_write(8'h5A);
    check("R8", "underrun cleared by write", int'(underrun), 0);
  endtask

  task automatic t_disabled;
    logic d, oe;
    logic [W-1:0] got;
    tx_en = 1'b0;
    one_tick(1'b1, d, oe);
    check("R9", "no slot with tx_en low", int'(oe), 0);
    check("R9", "word kept with tx_en low", int'(fifo_level), 1);
    tx_en = 1'b1; en = 1'b0;
    one_tick(1'b1, d, oe);
    check("R9", "no slot with en low", int'(oe), 0);
    check("R9", "word kept with en low", int'(fifo_level), 1);
    en = 1'b1;
    run_frame("R9", got);
    check("R9", "word sent after re-enable", int'(got), 'h5A);
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b0; tx_en = 1'b0; fifo_en = 1'b0;
    tx_ie = 1'b0; hold_ie = 1'b0; fifo_ie = 1'b0; thresh = 4'd0;
    wr_valid = 1'b0; wr_data = '0; bit_tick = 1'b0; fsync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    en = 1'b1; tx_en = 1'b1;
    t_hold_mode();
    t_fifo_mode();
    t_underrun();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule